// File: doc/BRIEF.md
# Clock-Generator Configuration Slave

This block is the two-wire serial configuration port of a clock-generator controller. A host reaches eight 8-bit registers through it. These registers hold the output enables, the stop-eligibility masks, the spread and drive controls and the identification byte. The register contents are presented in parallel to the clock-gating logic. The block synchronises the bus clock and data lines to a fast system clock and detects START and STOP conditions. It matches its fixed device address and answers with ACK or NACK. It pulls the shared data line low through an output-enable that drives an open-drain pad.

Four transaction forms are served. A byte write and a byte read (with a repeated START) address one register through the command byte. A block write and a block read carry a byte count and always begin at register 0. When power-good first asserts after reset, the block also captures three frequency-select strap pins and one debug-port select strap. It shows their levels in read-only fields that no bus write can alter.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset the registers read, from index 0 to 7: 0xFF, 0xFE, 0xFF, 0x00, 0x87, 0x00, 0x88, 0x11. Before the straps are captured, the strap fields read 0.
- R2: The slave ACKs the address byte only when its upper seven bits equal 0x69 (write byte 0xD2, read byte 0xD3; bit 0 is 1 for read). Any other address is NACKed, and the rest of that transaction is NACKed and leaves the registers unchanged.
- R3: A command byte with bit 7 set selects byte mode for the register in command bits 2..0. The first data byte of a byte write goes into that register, subject to the write masks of R7.
- R4: A byte read (address 0xD2, command, repeated START, address 0xD3) returns the register named by the command.
- R5: A command byte with bit 7 clear (0x00 in use) selects block mode. The first data byte of a block write is a count N. The next N data bytes are written to registers 0,1,2,… in order. Data bytes past N, and indices past 7, are ignored, yet every byte is ACKed.
- R6: A block read returns a count byte of 8, then registers 0 through 7 in order.
- R7: The following bits are read-only: register 7 holds the identification value 0x11, register 5 bit 0 and register 6 bits 2..0. All other bits are writable.
- R8: On the first cycle after reset that the synchronised active-low power-good input reads 0, the straps are captured. Register 6 bit 2 takes frequency-select C (`fs_strap_i[2]`), bit 1 takes B (`fs_strap_i[1]`) and bit 0 takes A (`fs_strap_i[0]`). Register 5 bit 0 takes the debug-select strap (1 = CPU clock on the shared pair, 0 = SRC clock). Later strap or power-good changes have no effect.
- R9: The slave turns its data drive on only while the synchronised bus clock is low, and it releases the data line after STOP.
- R10: `regs_o` carries register i at bits [8i+7:8i], with the read-only fields already merged in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock |
| sda_i | input | 1 | Serial bus data as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| pwrgd_ni | input | 1 | Active-low power-good |
| fs_strap_i | input | 3 | Frequency-select straps, bit 2 = C, bit 0 = A |
| itp_strap_i | input | 1 | Debug-port select strap |
| regs_o | output | 64 | All eight registers, register i at [8i+7:8i] |

## Verification
On every cycle the assertions check four things: the data drive turns on only while the bus clock is low, it is dropped after STOP, register writes happen only on a bus-clock rising edge outside read phases, and the captured strap fields stay frozen. Address matching, the command-byte mode split, the block count handling, the masks on read-only bits and the read ordering are visible only through whole transactions. The bench's scenarios drive these transactions, including a sweep of all 128 addresses and block writes whose counts fall short of and run past the register file.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned FS_W     = 3;
  localparam int unsigned ITP_REG  = 5;
  localparam int unsigned FS_REG   = 6;
  localparam int unsigned ID_REG   = 7;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} bus_state_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} rx_kind_e;

  function automatic logic [7:0] wr_mask(int unsigned idx);
    case (idx)
      ITP_REG: return 8'hFE;
      FS_REG:  return 8'hF8;
      ID_REG:  return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] rst_val(int unsigned idx);
    case (idx)
      1:       return 8'hFE;
      3:       return 8'h00;
      4:       return 8'h87;
      5:       return 8'h00;
      6:       return 8'h88;
      7:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
  parameter int unsigned   W       = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[b]}};
      else         ff <= {ff[0], d_i[b]};
    end
    assign q_o[b] = ff[1];
  end
endmodule

// File: rtl/clkcfg_strap.sv
module clkcfg_strap #(
  parameter int unsigned FS_W = clkcfg_pkg::FS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwrgd_ni,
  input  logic [FS_W-1:0] fs_i,
  input  logic            itp_i,
  output logic [FS_W-1:0] fs_o,
  output logic            itp_o,
  output logic            vld_o
);
  logic pwrgd_ns;

  clkcfg_sync #(.W(1), .RST_VAL(1'b1)) u_pg_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwrgd_ni), .q_o(pwrgd_ns)
  );

  // one-shot capture on first power-good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_o  <= '0;
      itp_o <= 1'b0;
      vld_o <= 1'b0;
    end else if (!pwrgd_ns && !vld_o) begin
      fs_o  <= fs_i;
      itp_o <= itp_i;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = clkcfg_pkg::NUM_REGS,
  parameter logic [7:0]  CHIP_ID  = 8'h11,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [FS_W-1:0]       fs_i,
  input  logic                  itp_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [7:0] WM = wr_mask(r);
    localparam logic [7:0] RV = rst_val(r);
    logic [7:0] q;
    logic [7:0] ro;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= RV;
      else if (we_i && waddr_i == IDX_W'(r))   q <= wdata_i;
    end

    if (r == ITP_REG) begin : g_itp
      assign ro = {7'b0, itp_i};
    end else if (r == FS_REG) begin : g_fs
      assign ro = {{(8-FS_W){1'b0}}, fs_i};
    end else if (r == ID_REG) begin : g_id
      assign ro = CHIP_ID;
    end else begin : g_rw
      assign ro = 8'h00;
    end

    assign regs_o[r*8 +: 8] = (q & WM) | ro;
  end
endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = clkcfg_pkg::NUM_REGS,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter logic [7:0]  CHIP_ID  = 8'h11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic                  pwrgd_ni,
  input  logic [2:0]            fs_strap_i,
  input  logic                  itp_strap_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  clkcfg_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o({scl_s, sda_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  logic [FS_W-1:0] strap_fs;
  logic            strap_itp, strap_vld;

  clkcfg_strap #(.FS_W(FS_W)) u_strap (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwrgd_ni(pwrgd_ni),
    .fs_i(fs_strap_i), .itp_i(itp_strap_i),
    .fs_o(strap_fs), .itp_o(strap_itp), .vld_o(strap_vld)
  );

  bus_state_e       state;
  rx_kind_e         kind;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, remaining;
  logic [IDX_W-1:0] byte_idx;
  logic [IDX_W:0]   ptr;
  logic             ack_drv, go_tx, blk_mode, need_cnt, wr_done, send_cnt;

  logic [7:0]       rx_byte, rd_byte, tx_next;
  logic             reg_we;
  logic [IDX_W-1:0] reg_waddr;

  assign rx_byte   = {shreg[6:0], sda_s};
  assign rd_byte   = ptr[IDX_W] ? 8'h00 : regs_o[int'(ptr[IDX_W-1:0])*8 +: 8];
  assign tx_next   = send_cnt ? 8'(NUM_REGS) : rd_byte;
  assign reg_waddr = blk_mode ? ptr[IDX_W-1:0] : byte_idx;

  always_comb begin
    reg_we = 1'b0;
    if (state == ST_RX && scl_rise && bitcnt == 4'd7 && kind == K_DATA) begin
      if (blk_mode) reg_we = !need_cnt && remaining != 8'd0 && !ptr[IDX_W];
      else          reg_we = !wr_done;
    end
  end

  clkcfg_regbank #(.NUM_REGS(NUM_REGS), .CHIP_ID(CHIP_ID)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we), .waddr_i(reg_waddr),
    .wdata_i(rx_byte), .fs_i(strap_fs), .itp_i(strap_itp), .regs_o(regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      remaining <= '0;
      byte_idx  <= '0;
      ptr       <= '0;
      ack_drv   <= 1'b0;
      go_tx     <= 1'b0;
      blk_mode  <= 1'b0;
      need_cnt  <= 1'b0;
      wr_done   <= 1'b0;
      send_cnt  <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (start_det) begin
      state    <= ST_RX;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      ack_drv  <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg  <= rx_byte;
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 4'd7) begin
            state   <= ST_RX_ACK;
            ack_drv <= 1'b0;
            go_tx   <= 1'b0;
            unique case (kind)
              K_ADDR: begin
                if (rx_byte[7:1] != DEV_ADDR) state <= ST_IDLE;
                else if (rx_byte[0]) begin
                  go_tx    <= 1'b1;
                  send_cnt <= blk_mode;
                  ptr      <= blk_mode ? '0 : {1'b0, byte_idx};
                end else kind <= K_CMD;
              end
              K_CMD: begin
                blk_mode <= ~rx_byte[7];
                byte_idx <= rx_byte[IDX_W-1:0];
                ptr      <= '0;
                need_cnt <= 1'b1;
                wr_done  <= 1'b0;
                kind     <= K_DATA;
              end
              default: begin
                if (!blk_mode) wr_done <= 1'b1;
                else if (need_cnt) begin
                  need_cnt  <= 1'b0;
                  remaining <= rx_byte;
                end else if (remaining != 8'd0) begin
                  remaining <= remaining - 1'b1;
                  if (!ptr[IDX_W]) ptr <= ptr + 1'b1;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          if (!ack_drv) begin
            sda_oe_o <= 1'b1;
            ack_drv  <= 1'b1;
          end else begin
            ack_drv <= 1'b0;
            bitcnt  <= '0;
            if (go_tx) begin
              shreg    <= tx_next;
              sda_oe_o <= ~tx_next[7];
              state    <= ST_TX;
              if (send_cnt) send_cnt <= 1'b0;
              else if (!ptr[IDX_W]) ptr <= ptr + 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) bitcnt <= bitcnt + 1'b1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TX_ACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_oe_o <= ~shreg[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_s) state <= ST_IDLE;  // master NACK ends the read
          end else if (scl_fall) begin
            shreg    <= tx_next;
            sda_oe_o <= ~tx_next[7];
            bitcnt   <= '0;
            state    <= ST_TX;
            if (send_cnt) send_cnt <= 1'b0;
            else if (!ptr[IDX_W]) ptr <= ptr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkgen_cfg_slave_chk.sv
module clkgen_cfg_slave_chk
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = clkcfg_pkg::NUM_REGS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  scl_s,
  input logic                  sda_oe_o,
  input logic                  stop_det,
  input logic                  scl_rise,
  input logic                  reg_we,
  input bus_state_e            state,
  input logic                  strap_vld,
  input logic [NUM_REGS*8-1:0] regs_o
);
  AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);  // R9

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);  // R9

  AST_WRITE_ON_SCL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we |-> scl_rise);  // R3

  AST_NO_WRITE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_TX || state == ST_TX_ACK) |-> !reg_we);  // R6

  AST_STRAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_vld && $past(strap_vld)) |->
      ($stable(regs_o[FS_REG*8 +: FS_W]) && $stable(regs_o[ITP_REG*8])));  // R8
endmodule

bind clkgen_cfg_slave clkgen_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .stop_det(stop_det), .scl_rise(scl_rise), .reg_we(reg_we), .state(state),
  .strap_vld(strap_vld), .regs_o(regs_o)
);

// File: tb/clkgen_cfg_slave_test.sv
`timescale 1ns/1ps
module clkgen_cfg_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_bus;
  logic        sda_oe;
  logic        pwrgd_n = 1'b1;
  logic [2:0]  fs = 3'b101;
  logic        itp = 1'b1;
  logic [63:0] regs;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] st [8];
  logic [2:0] s_fs  = 3'b000;
  logic       s_itp = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  clkgen_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .pwrgd_ni(pwrgd_n), .fs_strap_i(fs), .itp_strap_i(itp), .regs_o(regs)
  );

  function automatic logic [7:0] wm(int i);
    case (i) 5: return 8'hFE; 6: return 8'hF8; 7: return 8'h00; default: return 8'hFF; endcase
  endfunction

  function automatic logic [7:0] view(int i);
    case (i)
      5: return (st[5] & 8'hFE) | {7'b0, s_itp};
      6: return (st[6] & 8'hF8) | {5'b0, s_fs};
      7: return 8'h11;
      default: return st[i];
    endcase
  endfunction

  function automatic void model_wr(int i, logic [7:0] v);
    st[i] = (v & wm(i)) | (st[i] & ~wm(i));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    for (int i = 0; i < 8; i++) chk(tag, regs[i*8 +: 8], view(i));
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    m_sda = b;   wait_clk(6);
    m_scl = 1'b1; wait_clk(4);
    r = sda_bus; wait_clk(4);
    m_scl = 1'b0; wait_clk(2);
  endtask

  task automatic start_c;
    m_sda = 1'b1; wait_clk(4);
    m_scl = 1'b1; wait_clk(6);
    m_sda = 1'b0; wait_clk(6);
    m_scl = 1'b0; wait_clk(4);
  endtask

  task automatic stop_c;
    m_sda = 1'b0; wait_clk(4);
    m_scl = 1'b1; wait_clk(6);
    m_sda = 1'b1; wait_clk(6);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      b[i] = r;
    end
    bit_x(~ack, r);
  endtask

  task automatic byte_wr(input int idx, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    start_c;
    send_byte(8'hD2, a0);
    send_byte(8'h80 | 8'(idx), a1);
    send_byte(d, a2);
    stop_c;
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_rd(input int idx, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    start_c;
    send_byte(8'hD2, a0);
    send_byte(8'h80 | 8'(idx), a1);
    start_c;
    send_byte(8'hD3, a2);
    recv_byte(1'b0, d);
    stop_c;
    ok = a0 & a1 & a2;
  endtask

  task automatic blk_wr(input logic [7:0] cnt, input int nbytes, input logic [7:0] seed,
                        output logic ok);
    logic a;
    start_c;
    send_byte(8'hD2, a);       ok = a;
    send_byte(8'h00, a);       ok &= a;
    send_byte(cnt, a);         ok &= a;
    for (int k = 0; k < nbytes; k++) begin
      send_byte(seed + 8'(k * 29), a);
      ok &= a;
    end
    stop_c;
  endtask

  initial begin
    logic ok;
    logic [7:0] d;
    st[0] = 8'hFF; st[1] = 8'hFE; st[2] = 8'hFF; st[3] = 8'h00;
    st[4] = 8'h87; st[5] = 8'h00; st[6] = 8'h88; st[7] = 8'h00;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);

    // R1 reset values, straps not yet captured
    chk_regs("R1/R10 reset");
    chk("R9 idle release", {7'b0, sda_oe}, 8'h00);

    // R8 capture at first power-good
    pwrgd_n = 1'b0;
    wait_clk(6);
    s_fs = 3'b101; s_itp = 1'b1;
    chk_regs("R8 capture");
    fs = 3'b010; itp = 1'b0;
    pwrgd_n = 1'b1; wait_clk(6);
    pwrgd_n = 1'b0; wait_clk(6);
    chk_regs("R8 strap change ignored");

    // R2 address sweep
    for (int a = 0; a < 128; a++) begin
      logic ak;
      start_c;
      send_byte({a[6:0], 1'b0}, ak);
      stop_c;
      chk("R2 address ack", {7'b0, ak}, (a == 'h69) ? 8'h01 : 8'h00);
    end
    begin
      logic a0, a1, a2;
      start_c;
      send_byte(8'hD0, a0);
      send_byte(8'h80, a1);
      send_byte(8'h00, a2);
      stop_c;
      chk("R2 foreign nack", {5'b0, a0, a1, a2}, 8'h00);
    end
    chk_regs("R2 foreign no effect");

    // R3/R7 byte writes to every register
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(i * 8'h3B) ^ 8'hC6;
      byte_wr(i, v, ok);
      chk("R3 byte write ack", {7'b0, ok}, 8'h01);
      model_wr(i, v);
      chk_regs((i >= 5) ? "R7 read-only bits" : "R3 byte write");
    end

    // R4 byte reads
    for (int i = 0; i < 8; i++) begin
      byte_rd(i, d, ok);
      chk("R4 byte read ack", {7'b0, ok}, 8'h01);
      chk("R4 byte read data", d, view(i));
    end

    // R5 short block: count 3, five data bytes
    blk_wr(8'd3, 5, 8'h5A, ok);
    chk("R5 block ack all", {7'b0, ok}, 8'h01);
    for (int k = 0; k < 3; k++) model_wr(k, 8'h5A + 8'(k * 29));
    chk_regs("R5 short block");

    // R5/R7 long block: count 10, ten data bytes
    blk_wr(8'd10, 10, 8'h13, ok);
    chk("R5 long block ack all", {7'b0, ok}, 8'h01);
    for (int k = 0; k < 8; k++) model_wr(k, 8'h13 + 8'(k * 29));
    chk_regs("R5 long block");

    // R6 block read
    begin
      logic a0, a1, a2;
      start_c;
      send_byte(8'hD2, a0);
      send_byte(8'h00, a1);
      start_c;
      send_byte(8'hD3, a2);
      chk("R6 block read acks", {5'b0, a0, a1, a2}, 8'h07);
      recv_byte(1'b1, d);
      chk("R6 count byte", d, 8'd8);
      for (int i = 0; i < 8; i++) begin
        recv_byte(i != 7, d);
        chk("R6 block read data", d, view(i));
      end
      stop_c;
      wait_clk(4);
      chk("R9 release after stop", {7'b0, sda_oe}, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule